// File: doc/BRIEF.md
# Power-Good Supervisor with Deglitch Filter

This block turns two digitised window-comparator flags on a regulator output into a power-good indication. One flag reports that the output sits below its lower limit, which is 92% of nominal. The other reports that it sits above its upper limit, which is 110% of nominal. Either flag means the output is outside its window. The indication is an active-high pull-down request, `pg_pulldown`, which drives an external open-drain device. When the request is 1 the power-good line is held low. When it is 0 the line is released and the external pull-up takes it high.

A change in window status reaches the output only after the new status has held without interruption for a fixed deglitch time, nominally 25 µs. The filter works in both directions, so a brief excursion does not pull the line low and a brief return to the window does not release it. If the status flips back before the time is up, the count starts again. The converter can also be disabled or be in soft-start. In either case the output is forced low at once, bypassing the filter, and the filtered state is cleared. Releasing the line afterwards therefore needs a full deglitch period inside the window.

Top module: `pgood_supervisor`

## Requirements
- R1: While reset is asserted and right after it is removed, `pg_pulldown` is 1.
- R2: With the block enabled and not in soft-start, `under_flag`=1 held for DG_CYCLES consecutive clock edges sets `pg_pulldown` to 1 from the DG_CYCLES-th edge onward.
- R3: `over_flag`=1, or both flags at 1, held for DG_CYCLES consecutive edges has the same effect as R2.
- R4: `pg_pulldown` goes to 0 only after both flags have been 0 for DG_CYCLES consecutive edges, exactly at the DG_CYCLES-th edge.
- R5: A window status that differs from the filtered state for fewer than DG_CYCLES edges leaves `pg_pulldown` unchanged, and the next change must again last the full DG_CYCLES edges. This holds for excursions out of the window and for returns into it.
- R6: `run_enable`=0 drives `pg_pulldown` to 1 in the same cycle, without waiting for a clock edge.
- R7: `softstart_busy`=1 drives `pg_pulldown` to 1 in the same cycle, without waiting for a clock edge.
- R8: Once a forcing condition (R6, R7) ends, `pg_pulldown` stays 1 until both flags have been 0 for DG_CYCLES edges counted after the first edge with no forcing condition.
- R9: DG_CYCLES equals CLK_KHZ × DEGLITCH_NS / 1,000,000, rounded down, with a minimum of 1. For example, 400 kHz and 25,000 ns give 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| under_flag | input | 1 | Output below lower window limit |
| over_flag | input | 1 | Output above upper window limit |
| run_enable | input | 1 | Converter enabled (0 forces fault) |
| softstart_busy | input | 1 | Soft-start in progress (1 forces fault) |
| pg_pulldown | output | 1 | 1 = pull power-good line low |

## Verification
The filter is swept with out-of-window pulses on each flag alone and on both together, for every length from 1 to DG_CYCLES+2 edges. Each output sample is compared with the arithmetic rule that the fault shows at the DG_CYCLES-th edge. This separates a correct count from an off-by-one, and a pulse that just fails to trip from one that just trips. The same sweep is repeated in the other direction, with in-window pulses of varying length starting from a faulted state, to show that recovery is filtered too. The enable and soft-start inputs are toggled at different points of a running count. This shows that they act without a clock edge and that they wipe any partial count.

// File: rtl/pgood_supervisor.sv
module pgood_supervisor #(
  parameter int CLK_KHZ     = 200_000,
  parameter int DEGLITCH_NS = 25_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic under_flag,
  input  logic over_flag,
  input  logic run_enable,
  input  logic softstart_busy,
  output logic pg_pulldown
);
  localparam longint PROD    = longint'(CLK_KHZ) * longint'(DEGLITCH_NS);
  localparam int     RAW_DG  = int'(PROD / 64'd1_000_000);
  localparam int     DG_LEN  = (RAW_DG < 1) ? 1 : RAW_DG;
  localparam int     CW      = $clog2(DG_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(DG_LEN - 1);

  logic          in_window, force_low, good_q;
  logic [CW-1:0] cnt_q;

  assign in_window = ~under_flag & ~over_flag;
  assign force_low = ~run_enable | softstart_busy;
  assign pg_pulldown = force_low | ~good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= 1'b0;
      cnt_q  <= '0;
    end else if (force_low) begin
      good_q <= 1'b0;
      cnt_q  <= '0;
    end else if (in_window == good_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == LAST) begin
      good_q <= in_window;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_force_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> !good_q);

  assert_rise_needs_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_q) |-> $past(in_window) && $past(cnt_q) == LAST);

  assert_fall_filtered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(good_q) && !$past(force_low)) |-> (!$past(in_window) && $past(cnt_q) == LAST));

  assert_count_only_on_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ($past(in_window) != $past(good_q)) && !$past(force_low));

  assert_forced_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_enable |-> pg_pulldown);

  assert_forced_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    softstart_busy |-> pg_pulldown);
endmodule

// File: tb/pgood_supervisor_bench.sv
module pgood_supervisor_bench;
  localparam int KHZ = 400;
  localparam int DNS = 25_000;
  localparam int DG  = (KHZ * DNS) / 1_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0, ov = 1'b0, en = 1'b1, ss = 1'b0;
  logic pd;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgood_supervisor #(.CLK_KHZ(KHZ), .DEGLITCH_NS(DNS)) u_pgood_supervisor (
    .clk(clk), .rst_n(rst_n), .under_flag(uv), .over_flag(ov),
    .run_enable(en), .softstart_busy(ss), .pg_pulldown(pd));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (pd !== exp) begin
      errors++;
      $display("FAIL %s: pg_pulldown=%b expected %b at %0t", tag, pd, exp, $time);
    end
  endtask

  task automatic go_good();
    uv = 0; ov = 0;
    for (int i = 0; i < DG + 1; i++) tick();
    chk(1'b0, "R4 settle good");
  endtask

  task automatic go_bad();
    uv = 1; ov = 0;
    for (int i = 0; i < DG + 1; i++) tick();
    chk(1'b1, "R2 settle bad");
  endtask

  initial begin
    if (DG != 10) begin errors++; $display("FAIL R9: DG=%0d expected 10", DG); end
    checks++;
    tick(); tick();
    chk(1'b1, "R1 in reset");
    rst_n = 1'b1;
    for (int k = 1; k <= DG; k++) begin
      tick();
      chk(k < DG, "R1/R4 release after reset");
    end

    for (int mode = 0; mode < 3; mode++) begin
      for (int len = 1; len <= DG + 2; len++) begin
        go_good();
        uv = (mode != 1); ov = (mode != 0);
        for (int k = 1; k <= len; k++) begin
          tick();
          chk(k >= DG, mode == 0 ? "R2 under pulse" : "R3 over pulse");
        end
        uv = 0; ov = 0;
        if (len < DG) begin
          for (int k = 1; k <= DG + 1; k++) begin
            tick();
            chk(1'b0, "R5 short excursion ignored");
          end
        end else begin
          for (int k = 1; k <= DG; k++) begin
            tick();
            chk(k < DG, "R4 recovery timing");
          end
        end
      end
    end

    for (int len = 1; len <= DG + 2; len++) begin
      go_bad();
      uv = 0;
      for (int k = 1; k <= len; k++) begin
        tick();
        chk(k < DG, "R4 return pulse");
      end
      if (len < DG) begin
        uv = 1;
        tick();
        chk(1'b1, "R5 short return ignored");
        uv = 0;
        for (int k = 1; k <= DG; k++) begin
          tick();
          chk(k < DG, "R5 count restarted");
        end
      end
    end

    for (int which = 0; which < 2; which++) begin
      for (int mid = 0; mid < DG; mid += 3) begin
        go_bad();
        uv = 0;
        for (int k = 0; k < mid; k++) tick();
        if (which == 0) en = 0; else ss = 1;
        #0.5;
        chk(1'b1, which == 0 ? "R6 disable immediate" : "R7 softstart immediate");
        tick(); tick();
        if (which == 0) en = 1; else ss = 0;
        for (int k = 1; k <= DG; k++) begin
          tick();
          chk(k < DG, "R8 release after force");
        end
        if (which == 0) en = 0; else ss = 1;
        #0.5;
        chk(1'b1, which == 0 ? "R6 disable from good" : "R7 softstart from good");
        tick();
        if (which == 0) en = 1; else ss = 0;
        tick();
        chk(1'b1, "R8 filtered state cleared");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule